// File: doc/BRIEF.md
# Reference Divider with Three-State Phase-Frequency Detector

This block takes a reference oscillator, presented as a one-cycle strobe `ref_tick` in the system clock domain, and divides it by a programmable ratio. The result is a one-cycle reference pulse. That pulse is compared against a one-cycle feedback pulse from the loop's feedback divider. The comparison drives a single-ended three-state charge output, modelled as two enables. `pd_up_en` means drive the output high. `pd_dn_en` means drive it low. When both are low the output floats at high impedance. A lock indicator also comes out of the comparison.

Each input sets its own flag when its pulse arrives. The charge output drives while exactly one flag is set. Both flags clear in the cycle in which the second edge arrives. Because of this, a timing mismatch of even one clock cycle still produces a one-cycle correction. If feedback edges come early or arrive too often, the output gives low-going drive. If they come late or too rarely, it gives high-going drive. `lock_ok` stays high while neither flag is set and drops for exactly as long as the output drives.

A parameter `REG_OUT` chooses between two variants. With `REG_OUT = 0` the enables and the lock indicator come straight from the flags. With `REG_OUT = 1` they pass through an extra register stage. All timing given below is for the default `REG_OUT = 0`.

Top module: `refpd_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ref_pulse`, `pd_up_en` and `pd_dn_en` are 0 and `lock_ok` is 1.
- R2: `ref_pulse` is high for one clock cycle at a time. It fires on the first `ref_tick` after reset and then on every R-th `ref_tick`, where R is the value of `ref_ratio` (up to 16,383 with the default 14-bit width).
- R3: A `ref_ratio` value below 3 (that is, 0, 1 or 2) divides by 3.
- R4: `ref_ratio` is sampled only when the counter reloads. A change in the middle of a period leaves the current period's length alone and takes effect for the next period.
- R5: Suppose the reference pulse arrives d cycles before the feedback pulse, with no flag set. Then `pd_up_en` is high for exactly d cycles, starting in the cycle after `ref_pulse`, and `pd_dn_en` stays low.
- R6: Suppose the feedback pulse arrives d cycles before the reference pulse, with no flag set. Then `pd_dn_en` is high for exactly d cycles, starting in the cycle after `fb_pulse`, and `pd_up_en` stays low.
- R7: If `ref_pulse` and `fb_pulse` are both high in the same cycle and no flag is set, the output stays at high impedance (both enables 0).
- R8: A one-cycle mismatch in either direction produces a one-cycle drive pulse.
- R9: `pd_up_en` and `pd_dn_en` are never high together.
- R10: `lock_ok` is 0 exactly when `pd_up_en` or `pd_dn_en` is 1.
- R11: A feedback pulse train that runs faster than the reference produces only `pd_dn_en` drive. A slower one produces only `pd_up_en` drive.
- R12: A second pulse on the same input while that input's flag is already set has no effect. The drive lasts from the first pulse until the other input's pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | One-cycle strobe per reference oscillator period |
| ref_ratio | input | RATIO_W (14) | Reference divide ratio R |
| fb_pulse | input | 1 | One-cycle feedback pulse from the N divider |
| ref_pulse | output | 1 | One-cycle divided reference pulse |
| pd_up_en | output | 1 | Drive the detector output high |
| pd_dn_en | output | 1 | Drive the detector output low |
| lock_ok | output | 1 | High while neither flag is set |

## Verification
Two events can land in the same cycle. The first is the arrival of the reference edge and the feedback edge together. This is provoked by asserting `fb_pulse` in exactly the cycle `ref_pulse` is high, and it is judged by both enables staying low and `lock_ok` staying high for two whole periods. The second is a divider reload coinciding with a new ratio. Here `ref_ratio` is changed partway through a period, and the bench confirms that the old length finishes before the new one starts. The lead and lag cases are swept down to a single cycle of offset, so the coincidence case is bracketed from both sides.

// File: rtl/refpd_pkg.sv
package refpd_pkg;

   // Encoded state of the three-state detector output
   typedef enum logic [1:0] {
      PD_HIZ  = 2'b00,
      PD_PUMP = 2'b01,
      PD_SINK = 2'b10
   } pd_state_e;

   // Lowest legal divide ratio; smaller programmed values are raised to it
   localparam int unsigned FLOOR_RATIO = 3;

endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
   parameter int unsigned RATIO_W   = 14,
   parameter int unsigned MIN_RATIO = refpd_pkg::FLOOR_RATIO
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [RATIO_W-1:0] ratio,
   output logic               pulse
);

   localparam logic [RATIO_W-1:0] MIN_R = RATIO_W'(MIN_RATIO);
   localparam logic [RATIO_W-1:0] ONE_R = RATIO_W'(1);

   logic [RATIO_W-1:0] cnt_q;
   logic [RATIO_W-1:0] eff_ratio;
   logic               term;

   // Clamp short ratios up to the floor
   always_comb begin
      eff_ratio = (ratio < MIN_R) ? MIN_R : ratio;
   end

   // Terminal count: counter at one (or zero just after reset)
   assign term = (cnt_q <= ONE_R);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pulse <= 1'b0;
      end else begin
         pulse <= 1'b0;
         if (tick) begin
            if (term) begin
               cnt_q <= eff_ratio;
               pulse <= 1'b1;
            end else begin
               cnt_q <= cnt_q - ONE_R;
            end
         end
      end
   end

endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_edge,
   input  logic fb_edge,
   output logic flag_ref,
   output logic flag_fb,
   output logic drv_up,
   output logic drv_dn
);

   import refpd_pkg::*;

   logic      nxt_ref;
   logic      nxt_fb;
   pd_state_e st;

   // Each edge sets its flag; once both would be set, both clear
   always_comb begin
      nxt_ref = flag_ref | ref_edge;
      nxt_fb  = flag_fb  | fb_edge;
      if (nxt_ref && nxt_fb) begin
         nxt_ref = 1'b0;
         nxt_fb  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_ref <= 1'b0;
         flag_fb  <= 1'b0;
      end else begin
         flag_ref <= nxt_ref;
         flag_fb  <= nxt_fb;
      end
   end

   always_comb begin
      unique case ({flag_ref, flag_fb})
         2'b10:   st = PD_PUMP;
         2'b01:   st = PD_SINK;
         default: st = PD_HIZ;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg_out
         pd_state_e st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= PD_HIZ;
            else        st_q <= st;
         end
         assign drv_up = (st_q == PD_PUMP);
         assign drv_dn = (st_q == PD_SINK);
      end else begin : g_comb_out
         assign drv_up = (st == PD_PUMP);
         assign drv_dn = (st == PD_SINK);
      end
   endgenerate

endmodule

// File: rtl/lock_detect.sv
module lock_detect #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_a,
   input  logic flag_b,
   output logic locked
);

   logic idle;
   assign idle = ~(flag_a | flag_b);

   generate
      if (REG_OUT) begin : g_reg_lock
         logic lk_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lk_q <= 1'b1;
            else        lk_q <= idle;
         end
         assign locked = lk_q;
      end else begin : g_comb_lock
         assign locked = idle;
      end
   endgenerate

endmodule

// File: rtl/refpd_top.sv
module refpd_top #(
   parameter int unsigned RATIO_W   = 14,
   parameter int unsigned MIN_RATIO = refpd_pkg::FLOOR_RATIO,
   parameter bit          REG_OUT   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_tick,
   input  logic [RATIO_W-1:0] ref_ratio,
   input  logic               fb_pulse,
   output logic               ref_pulse,
   output logic               pd_up_en,
   output logic               pd_dn_en,
   output logic               lock_ok
);

   generate
      if (RATIO_W < 2 || RATIO_W > 32) begin : g_bad_width
         $error("refpd_top: RATIO_W out of range");
      end
      if (MIN_RATIO < 2 || MIN_RATIO >= (64'd1 << RATIO_W)) begin : g_bad_floor
         $error("refpd_top: MIN_RATIO does not fit RATIO_W");
      end
   endgenerate

   logic flag_ref;
   logic flag_fb;

   ref_divider #(
      .RATIO_W  (RATIO_W),
      .MIN_RATIO(MIN_RATIO)
   ) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (ref_tick),
      .ratio(ref_ratio),
      .pulse(ref_pulse)
   );

   pfd_core #(
      .REG_OUT(REG_OUT)
   ) u_pfd (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_edge(ref_pulse),
      .fb_edge (fb_pulse),
      .flag_ref(flag_ref),
      .flag_fb (flag_fb),
      .drv_up  (pd_up_en),
      .drv_dn  (pd_dn_en)
   );

   lock_detect #(
      .REG_OUT(REG_OUT)
   ) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .flag_a(flag_ref),
      .flag_b(flag_fb),
      .locked(lock_ok)
   );

endmodule

// File: rtl/refpd_chk.sv
module refpd_chk #(
   parameter bit REG_OUT = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic ref_tick,
   input logic fb_pulse,
   input logic ref_pulse,
   input logic pd_up_en,
   input logic pd_dn_en,
   input logic lock_ok
);

   // R9
   excl_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pd_up_en && pd_dn_en));

   // R10
   lock_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_ok == !(pd_up_en || pd_dn_en));

   // R2
   ref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pulse |=> !ref_pulse);

   // R2
   ref_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pulse |-> $past(ref_tick));

   generate
      if (!REG_OUT) begin : g_timing
         // R5
         lag_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_pulse && !fb_pulse && !pd_dn_en) |=> pd_up_en);

         // R6
         lead_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fb_pulse && !ref_pulse && !pd_up_en) |=> pd_dn_en);

         // R7
         coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_pulse && fb_pulse && !pd_up_en && !pd_dn_en)
            |=> (!pd_up_en && !pd_dn_en));
      end
   endgenerate

endmodule

bind refpd_top refpd_chk #(.REG_OUT(REG_OUT)) u_refpd_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ref_tick (ref_tick),
   .fb_pulse (fb_pulse),
   .ref_pulse(ref_pulse),
   .pd_up_en (pd_up_en),
   .pd_dn_en (pd_dn_en),
   .lock_ok  (lock_ok)
);

// File: tb/tb_refpd_top.sv
`timescale 1ns/1ps
module tb_refpd_top;

   localparam int W = 14;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ref_tick = 1'b0;
   logic [W-1:0] ref_ratio = '0;
   logic         fb_pulse = 1'b0;
   logic         ref_pulse, pd_up_en, pd_dn_en, lock_ok;

   logic s_ref, s_up, s_dn, s_lock;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   refpd_top #(.RATIO_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ref_ratio(ref_ratio),
      .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .pd_up_en(pd_up_en),
      .pd_dn_en(pd_dn_en), .lock_ok(lock_ok)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input bit t, input bit f);
      @(negedge clk);
      ref_tick = t;
      fb_pulse = f;
      @(posedge clk);
      #1;
      s_ref = ref_pulse; s_up = pd_up_en; s_dn = pd_dn_en; s_lock = lock_ok;
   endtask

   task automatic do_reset(input int ratio);
      @(negedge clk);
      rst_n = 1'b0; ref_tick = 1'b0; fb_pulse = 1'b0;
      ref_ratio = W'(ratio);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // R1: reset state
   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(!ref_pulse && !pd_up_en && !pd_dn_en && lock_ok, "R1 in reset",
            {ref_pulse, pd_up_en, pd_dn_en, lock_ok}, 1);
      do_reset(20);
      cyc(1'b0, 1'b0);
      check(!s_ref && !s_up && !s_dn && s_lock, "R1 after reset",
            {s_ref, s_up, s_dn, s_lock}, 1);
   endtask

   // R2 / R3: pulse spacing for a ratio and tick cadence
   task automatic t_period(input int ratio, input int gap, input int exp, input string tag);
      int pos [3];
      int np = 0;
      int wide = 0;
      do_reset(ratio);
      for (int k = 1; k <= exp * 2 + 4 && np < 3; k++) begin
         cyc((gap == 1) || (k % gap == 1), 1'b0);
         if (s_ref) begin
            pos[np] = k;
            np++;
         end
      end
      check(np == 3, {tag, " pulse count"}, np, 3);
      if (np == 3) begin
         check(pos[0] == 1, {tag, " first pulse"}, pos[0], 1);
         check(pos[1] - pos[0] == exp, {tag, " interval 1"}, pos[1] - pos[0], exp);
         check(pos[2] - pos[1] == exp, {tag, " interval 2"}, pos[2] - pos[1], exp);
      end
      // one cycle wide: next sample after a pulse is low
      cyc(1'b0, 1'b0);
      wide = s_ref;
      check(wide == 0, {tag, " pulse width"}, wide, 0);
   endtask

   // R4: ratio change mid-period
   task automatic t_reload();
      int pos [3];
      int np = 0;
      do_reset(10);
      for (int k = 1; k <= 20 && np < 3; k++) begin
         if (k == 5) ref_ratio = W'(4);
         cyc(1'b1, 1'b0);
         if (s_ref) begin
            pos[np] = k;
            np++;
         end
      end
      check(np == 3 && pos[1] == 11, "R4 old period kept", pos[1], 11);
      check(np == 3 && pos[2] == 15, "R4 new period used", pos[2], 15);
   endtask

   // R5 / R8: reference leads feedback by d cycles
   task automatic t_lag(input int d, input string tag);
      int hi = 0, lo = 0, bad = 0;
      do_reset(20);
      for (int k = 1; k <= 20; k++) begin
         cyc(1'b1, k == 2 + d);
         hi += s_up; lo += s_dn;
         if (s_lock != !(s_up || s_dn)) bad++;
      end
      check(hi == d, {tag, " up cycles"}, hi, d);
      check(lo == 0, {tag, " no down drive"}, lo, 0);
      check(bad == 0, "R10 lock tracks drive (lag)", bad, 0);
   endtask

   // R6 / R8: feedback leads reference by d cycles
   task automatic t_lead(input int d, input string tag);
      int hi = 0, lo = 0, bad = 0;
      do_reset(20);
      cyc(1'b1, 1'b0);
      for (int k = 2; k <= 23; k++) begin
         cyc(1'b1, (k == 2) || (k == 22 - d));
         hi += s_up; lo += s_dn;
         if (s_lock != !(s_up || s_dn)) bad++;
      end
      check(lo == d, {tag, " down cycles"}, lo, d);
      check(hi == 0, {tag, " no up drive"}, hi, 0);
      check(bad == 0, "R10 lock tracks drive (lead)", bad, 0);
   endtask

   // R7: coincident edges
   task automatic t_coincide();
      int drv = 0, unl = 0;
      do_reset(20);
      for (int k = 1; k <= 44; k++) begin
         cyc(1'b1, (k == 2) || (k == 22) || (k == 42));
         drv += s_up + s_dn;
         unl += !s_lock;
      end
      check(drv == 0, "R7 no drive at coincidence", drv, 0);
      check(unl == 0, "R7 lock held at coincidence", unl, 0);
   endtask

   // R12: repeated feedback pulse while its flag is set
   task automatic t_repeat();
      int hi = 0, lo = 0;
      do_reset(20);
      cyc(1'b1, 1'b0);
      for (int k = 2; k <= 23; k++) begin
         cyc(1'b1, (k == 2) || (k == 17) || (k == 19));
         hi += s_up; lo += s_dn;
      end
      check(lo == 5, "R12 down span from first pulse", lo, 5);
      check(hi == 0, "R12 no up drive", hi, 0);
   endtask

   // R11: frequency offset in either direction
   task automatic t_freq(input int fb_per, input bit fast);
      int hi = 0, lo = 0;
      do_reset(20);
      for (int k = 1; k <= 240; k++) begin
         cyc(1'b1, (k >= 2) && ((k - 2) % fb_per == 0));
         if (k >= 30) begin
            hi += s_up; lo += s_dn;
         end
      end
      if (fast) begin
         check(hi == 0, "R11 fast feedback gives no up drive", hi, 0);
         check(lo > 0, "R11 fast feedback gives down drive", lo, 1);
      end else begin
         check(lo == 0, "R11 slow feedback gives no down drive", lo, 0);
         check(hi > 0, "R11 slow feedback gives up drive", hi, 1);
      end
   endtask

   initial begin
      t_reset();
      t_period(5, 1, 5, "R2 every tick");
      t_period(5, 2, 10, "R2 alternate ticks");
      t_period(16383, 1, 16383, "R2 max ratio");
      t_period(0, 1, 3, "R3 ratio 0");
      t_period(2, 1, 3, "R3 ratio 2");
      t_period(3, 1, 3, "R3 ratio 3");
      t_reload();
      t_lag(4, "R5 lag 4");
      t_lag(1, "R8 lag 1");
      t_lead(6, "R6 lead 6");
      t_lead(1, "R8 lead 1");
      t_coincide();
      t_repeat();
      t_freq(15, 1'b1);
      t_freq(25, 1'b0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(150000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule